// File: doc/BRIEF.md
# Link Frame Classifier and Address Matcher

This block sits behind a link deserializer. Each time a complete 36-bit frame has been received, the deserializer raises a one-cycle strobe. It presents the frame's 8-bit address field, its 4-bit control field and a single bit saying whether the frame's check code verified. The block sorts the frame into one of these kinds:

- bus data for the lower, upper or quad supply;
- special-supply data;
- a keep-alive frame;
- a link-clear frame;
- a link-integrity frame;
- a bad frame.

For data frames it also compares the location part of the address with the wired-in house number of this station. When the two agree, it raises a pass pulse so that the data can be forwarded to the local controller.

Every result is a registered one-cycle pulse, issued on the clock edge that samples the strobe. A link-clear frame opens a hold window of a fixed number of cycles. During that window any further strobe is ignored. The clear that a link-clear frame triggers wipes the deserializer, and the strobe it can then produce must not be counted as a bad frame.

Top module: `link_frame_sorter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is 0. This holds even if a strobe is presented during reset.
- R2: A checked-good frame is a bus data frame when address bits [7:6] are 00 (lower), 01 (upper) or 10 (quad) and bits [5:0] lie in 0x00..0x18. For such a frame, `data_p` pulses and `bus_o` carries bits [7:6] in the cycle after the strobe.
- R3: A checked-good frame with an address in 0xD9..0xDF is a special-supply data frame. It gives `data_p` with `bus_o` = 11. The control field is ignored for all data frames.
- R4: `pass_p` pulses together with `data_p` exactly when address bits [4:0] equal `house_num`. It is never raised for any other frame kind.
- R5: A checked-good frame with address 0xFA and control 1010 gives `sa_p`.
- R6: A checked-good frame with address 0xFE and control 1110 gives `li_p`.
- R7: A checked-good frame with address 0xFC and control 1100 gives `lc_p`, and raises `lc_held_o` in the same cycle. `lc_held_o` stays high for HOLD_CYC (default 8) cycles and then falls.
- R8: A frame whose check bit is 0 gives `bad_p` and no other kind, whatever its fields.
- R9: A checked-good frame that matches none of R2, R3, R5, R6 or R7 gives `bad_p`. This covers an out-of-range location and a service address with the wrong control pattern.
- R10: A strobe sampled while `lc_held_o` is high produces no output pulse. With the default window, a strobe on the 8th edge after the link-clear edge is ignored and one on the 9th is sorted.
- R11: At most one of `data_p`, `sa_p`, `lc_p`, `li_p`, `bad_p` is high in any cycle. `bus_o` is 00 whenever `data_p` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_stb | input | 1 | One-cycle strobe: frame fields are valid |
| fr_addr | input | 8 | Frame address field |
| fr_ctl | input | 4 | Frame control field |
| fr_chk_ok | input | 1 | Frame check code verified |
| house_num | input | 5 | Wired-in house number of this station |
| data_p | output | 1 | Data frame pulse (bus or special) |
| pass_p | output | 1 | Data frame addressed to this house |
| bus_o | output | 2 | Selected bus during `data_p` (11 = special) |
| sa_p | output | 1 | Keep-alive frame pulse |
| lc_p | output | 1 | Link-clear frame pulse |
| li_p | output | 1 | Link-integrity frame pulse |
| bad_p | output | 1 | Bad frame pulse |
| lc_held_o | output | 1 | Link-clear hold window active |

## Verification
The hardest situation to bring about is the edge of the link-clear hold window. A strobe must land on exactly the last held edge, and then on the first free edge, after a link-clear frame. The stimulus reaches it by following a link-clear frame with a counted number of idle cycles before the next strobe. It checks both the ignored strobe and the sorted one, along with the fall of `lc_held_o`.

Beyond that, every address value is swept against every control pattern and both check-bit values, for three house numbers. Each link-clear hit in the sweep is followed by enough idle cycles to clear the window.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned CTL_W   = 4;
    localparam int unsigned BUS_W   = 2;
    localparam int unsigned HOUSE_W = 5;
    localparam int unsigned N_SVC   = 3;

    // service frame slots, order used by the match vector
    localparam int unsigned SVC_SA = 0;
    localparam int unsigned SVC_LC = 1;
    localparam int unsigned SVC_LI = 2;

    typedef struct packed {
        logic               data;
        logic               pass;
        logic [BUS_W-1:0]   bus;
        logic               sa;
        logic               lc;
        logic               li;
        logic               bad;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{default: '0};

endpackage

// File: rtl/lfs_addr_dec.sv
module lfs_addr_dec
    import lfs_pkg::*;
#(
    parameter int unsigned LOC_MAX = 'h18,
    parameter int unsigned SPS_LO  = 'h19,
    parameter int unsigned SPS_HI  = 'h1F
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              data_o,
    output logic [BUS_W-1:0]  bus_o
);

    localparam int unsigned LOC_W = ADDR_W - BUS_W;
    localparam logic [LOC_W-1:0] LOC_MAX_C = LOC_W'(LOC_MAX);
    localparam logic [LOC_W-1:0] SPS_LO_C  = LOC_W'(SPS_LO);
    localparam logic [LOC_W-1:0] SPS_HI_C  = LOC_W'(SPS_HI);

    logic [BUS_W-1:0] bus_f;
    logic [LOC_W-1:0] loc_f;
    logic             spec_sel;
    logic             bus_ok;
    logic             spec_ok;

    always_comb begin
        bus_f    = addr_i[ADDR_W-1 -: BUS_W];
        loc_f    = addr_i[LOC_W-1:0];
        spec_sel = &bus_f;
        bus_ok   = !spec_sel && (loc_f <= LOC_MAX_C);
        spec_ok  = spec_sel && (loc_f >= SPS_LO_C) && (loc_f <= SPS_HI_C);
        data_o   = bus_ok || spec_ok;
        bus_o    = data_o ? bus_f : '0;
    end

endmodule

// File: rtl/lfs_svc_match.sv
module lfs_svc_match
    import lfs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SA_ADDR = 8'hFA,
    parameter logic [CTL_W-1:0]  SA_CTL  = 4'b1010,
    parameter logic [ADDR_W-1:0] LC_ADDR = 8'hFC,
    parameter logic [CTL_W-1:0]  LC_CTL  = 4'b1100,
    parameter logic [ADDR_W-1:0] LI_ADDR = 8'hFE,
    parameter logic [CTL_W-1:0]  LI_CTL  = 4'b1110
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CTL_W-1:0]  ctl_i,
    output logic [N_SVC-1:0]  hit_o
);

    localparam logic [ADDR_W-1:0] SVC_ADDR [N_SVC] = '{SA_ADDR, LC_ADDR, LI_ADDR};
    localparam logic [CTL_W-1:0]  SVC_CTL  [N_SVC] = '{SA_CTL, LC_CTL, LI_CTL};

    // address and control pattern must both agree
    for (genvar g = 0; g < N_SVC; g++) begin : g_svc
        assign hit_o[g] = (addr_i == SVC_ADDR[g]) && (ctl_i == SVC_CTL[g]);
    end

endmodule

// File: rtl/lfs_lc_hold.sv
module lfs_lc_hold #(
    parameter int unsigned HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic held_o
);

    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(HOLD_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = CNT_INIT;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{default: '0};
        else        st_q <= st_d;
    end

    assign held_o = (st_q.cnt != '0);

    // R7: window counts down one per cycle until reloaded
    a_r7_hold_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !load_i) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R7: a load always opens the full window
    a_r7_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == CNT_INIT));

endmodule

// File: rtl/link_frame_sorter.sv
module link_frame_sorter
    import lfs_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fr_stb,
    input  logic [ADDR_W-1:0]  fr_addr,
    input  logic [CTL_W-1:0]   fr_ctl,
    input  logic               fr_chk_ok,
    input  logic [HOUSE_W-1:0] house_num,
    output logic               data_p,
    output logic               pass_p,
    output logic [BUS_W-1:0]   bus_o,
    output logic               sa_p,
    output logic               lc_p,
    output logic               li_p,
    output logic               bad_p,
    output logic               lc_held_o
);

    logic             is_data;
    logic [BUS_W-1:0] data_bus;
    logic [N_SVC-1:0] svc_hit;
    logic             held;

    verdict_t vd_d, vd_q;

    lfs_addr_dec u_addr_dec (
        .addr_i (fr_addr),
        .data_o (is_data),
        .bus_o  (data_bus)
    );

    lfs_svc_match u_svc_match (
        .addr_i (fr_addr),
        .ctl_i  (fr_ctl),
        .hit_o  (svc_hit)
    );

    lfs_lc_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) u_lc_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (vd_d.lc),
        .held_o (held)
    );

    always_comb begin
        vd_d = VERDICT_IDLE;
        if (fr_stb && !held) begin
            if (!fr_chk_ok) begin
                vd_d.bad = 1'b1;
            end else if (is_data) begin
                vd_d.data = 1'b1;
                vd_d.bus  = data_bus;
                vd_d.pass = (fr_addr[HOUSE_W-1:0] == house_num);
            end else if (svc_hit[SVC_SA]) begin
                vd_d.sa = 1'b1;
            end else if (svc_hit[SVC_LC]) begin
                vd_d.lc = 1'b1;
            end else if (svc_hit[SVC_LI]) begin
                vd_d.li = 1'b1;
            end else begin
                vd_d.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vd_q <= VERDICT_IDLE;
        else        vd_q <= vd_d;
    end

    assign data_p    = vd_q.data;
    assign pass_p    = vd_q.pass;
    assign bus_o     = vd_q.bus;
    assign sa_p      = vd_q.sa;
    assign lc_p      = vd_q.lc;
    assign li_p      = vd_q.li;
    assign bad_p     = vd_q.bad;
    assign lc_held_o = held;

    // R11: one verdict kind per cycle at most
    a_r11_single_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_p, sa_p, lc_p, li_p, bad_p}));

    // R11: bus select idles at zero outside data pulses
    a_r11_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !data_p |-> (bus_o == '0));

    // R4: pass only rides on a data pulse
    a_r4_pass_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        pass_p |-> data_p);

    // R7: link-clear pulse and hold window rise together
    a_r7_clear_arms_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lc_p |-> lc_held_o);

    // R8: a failed check yields a bad-frame pulse
    a_r8_fail_is_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_stb && !lc_held_o && !fr_chk_ok) |=> bad_p);

    // R10: strobes inside the hold window are dropped
    a_r10_quiet_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_stb && lc_held_o) |=> !(data_p || sa_p || lc_p || li_p || bad_p));

endmodule

// File: tb/link_frame_sorter_tb_top.sv
`timescale 1ns/1ps
module link_frame_sorter_tb_top;

    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fr_stb = 1'b0;
    logic [7:0] fr_addr = '0;
    logic [3:0] fr_ctl = '0;
    logic       fr_chk_ok = 1'b0;
    logic [4:0] house_num = '0;
    logic       data_p, pass_p, sa_p, lc_p, li_p, bad_p, lc_held_o;
    logic [1:0] bus_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    link_frame_sorter #(.HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .fr_stb(fr_stb), .fr_addr(fr_addr),
        .fr_ctl(fr_ctl), .fr_chk_ok(fr_chk_ok), .house_num(house_num),
        .data_p(data_p), .pass_p(pass_p), .bus_o(bus_o), .sa_p(sa_p),
        .lc_p(lc_p), .li_p(li_p), .bad_p(bad_p), .lc_held_o(lc_held_o)
    );

    // {data, pass, bus[1:0], sa, lc, li, bad}
    function automatic logic [7:0] observed();
        return {data_p, pass_p, bus_o, sa_p, lc_p, li_p, bad_p};
    endfunction

    function automatic logic [7:0] expect_of(logic [7:0] a, logic [3:0] c,
                                             logic ok, logic [4:0] h);
        logic [7:0] e = '0;
        if (!ok) begin
            e[0] = 1'b1;
        end else if ((a[7:6] != 2'b11 && a[5:0] <= 6'h18) ||
                     (a >= 8'hD9 && a <= 8'hDF)) begin
            e[7]   = 1'b1;
            e[6]   = (a[4:0] == h);
            e[5:4] = a[7:6];
        end else if (a == 8'hFA && c == 4'b1010) begin
            e[3] = 1'b1;
        end else if (a == 8'hFC && c == 4'b1100) begin
            e[2] = 1'b1;
        end else if (a == 8'hFE && c == 4'b1110) begin
            e[1] = 1'b1;
        end else begin
            e[0] = 1'b1;
        end
        return e;
    endfunction

    function automatic string tag_of(logic [7:0] e, logic ok, logic [7:0] a);
        if (!ok)       return "R8";
        if (e[7])      return (a[7:6] == 2'b11) ? "R3" : "R2";
        if (e[3])      return "R5";
        if (e[2])      return "R7";
        if (e[1])      return "R6";
        return "R9";
    endfunction

    task automatic check_vec(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // strobe sampled on the next posedge; sample result on the negedge after
    task automatic send(logic [7:0] a, logic [3:0] c, logic ok);
        @(negedge clk);
        fr_addr = a; fr_ctl = c; fr_chk_ok = ok; fr_stb = 1'b1;
        @(negedge clk);
        fr_stb = 1'b0;
    endtask

    task automatic send_check(logic [7:0] a, logic [3:0] c, logic ok);
        logic [7:0] e;
        string t;
        send(a, c, ok);
        e = expect_of(a, c, ok, house_num);
        t = tag_of(e, ok, a);
        if (observed()[6] !== e[6]) t = "R4";
        check_vec(t, observed(), e);
        if (e[2]) begin
            check_bit("R7", lc_held_o, 1'b1);
            idle(HOLD);
        end
    endtask

    initial begin : watchdog
        #(5.0 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [4:0] houses [3] = '{5'h00, 5'h18, 5'h1C};

        // R1: strobe during reset must not produce anything
        rst_n = 1'b0;
        fr_addr = 8'hFA; fr_ctl = 4'b1010; fr_chk_ok = 1'b1; fr_stb = 1'b1;
        idle(3);
        fr_stb = 1'b0;
        check_vec("R1", observed(), 8'h00);
        check_bit("R1", lc_held_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1", observed(), 8'h00);

        // directed: R2 lower bus matching house, R4 pass
        house_num = 5'h05;
        send(8'h05, 4'h0, 1'b1);
        check_vec("R2", observed(), 8'b1_1_00_0000);
        send(8'h45, 4'hF, 1'b1);
        check_vec("R4", observed(), 8'b1_1_01_0000);
        send(8'h99, 4'h0, 1'b1);   // quad, location 0x19 out of range
        check_vec("R9", observed(), 8'b0000_0001);
        send(8'hFA, 4'b1011, 1'b1);  // wrong control pattern
        check_vec("R9", observed(), 8'b0000_0001);
        send(8'hFE, 4'b1110, 1'b0);
        check_vec("R8", observed(), 8'b0000_0001);
        // pulse lasts one cycle
        @(negedge clk);
        check_vec("R11", observed(), 8'h00);

        // R10: hold window boundary
        send(8'hFC, 4'b1100, 1'b1);
        check_vec("R7", observed(), 8'b0000_0100);
        check_bit("R7", lc_held_o, 1'b1);
        idle(HOLD - 2);
        send(8'hFA, 4'b1010, 1'b1);   // lands on the 8th edge
        check_vec("R10", observed(), 8'h00);
        check_bit("R7", lc_held_o, 1'b0);
        send(8'hFC, 4'b1100, 1'b1);
        check_vec("R7", observed(), 8'b0000_0100);
        idle(HOLD - 2);
        check_bit("R7", lc_held_o, 1'b1);
        @(negedge clk);
        send(8'hFA, 4'b1010, 1'b1);   // lands on the 9th edge
        check_vec("R10", observed(), 8'b0000_1000);

        // exhaustive sweep: address x control x check bit, three houses
        foreach (houses[hi]) begin
            house_num = houses[hi];
            for (int a = 0; a < 256; a++) begin
                for (int c = 0; c < 16; c++) begin
                    for (int ok = 0; ok < 2; ok++) begin
                        send_check(8'(a), 4'(c), 1'(ok));
                    end
                end
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule